// File: doc/BRIEF.md
# Double-Buffered Byte-Lane DAC Code Register

This block is the digital front end of a parallel-input 16-bit converter, modelled on one fast system clock. A 16-bit data bus is written into an input register one byte lane at a time, or as a whole word. Each lane has its own active-low select, and an active-low write strobe gates the write. A separate active-low load strobe moves the input register into the DAC register, whose contents drive the output code. Each stage follows its source while its strobe is low, and it keeps the last value when the strobe returns high. When both stages are open at once, bus changes pass straight through to the output code.

All control pins cross into the clock domain through synchronisers. The data bus is delayed by the same number of stages, so data and controls stay aligned. An active-low clear forces both registers to midscale or to zero, depending on a select pin. Reset loads that same value. A one-cycle flag marks every change of the output code.

Top module: `dbd_dac_front`

## Requirements
- R1: After reset, `code_out` is 0x8000 if `clr_mid` was high during reset, or 0x0000 if it was low, and `code_chg` is 0.
- R2: While `wr_n` and `sel_lo_n` are both low, input register bits 7..0 follow `bus_in[7:0]`; bits 15..8 are untouched unless `sel_hi_n` is also low.
- R3: While `wr_n` and `sel_hi_n` are both low, input register bits 15..8 follow `bus_in[15:8]`; the two lanes may be written in either order.
- R4: With both selects low during a write, all 16 bits of the input register load together.
- R5: Once `wr_n` returns high, the input register keeps the bus value from the last cycle in which it was open, and later bus changes have no effect on it.
- R6: While `ld_n` is low, the DAC register follows the input register, whatever the selects are; once `ld_n` is high the DAC register holds.
- R7: With `wr_n`, both selects and `ld_n` all low, a bus change reaches `code_out` exactly SYNC_STAGES+1 clock edges after it is applied (3 by default).
- R8: With `wr_n` and `ld_n` low and only one select low, `code_out` is the live bus byte in the open lane combined with the stored byte of the closed lane.
- R9: While `clr_n` is low, both registers take 0x8000 if `clr_mid` is high, or 0x0000 if it is low. Clear overrides any write or load in the same cycle.
- R10: `code_chg` is high for exactly one cycle after every cycle in which the DAC register value changed, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous power-on reset |
| bus_in | input | 16 | Parallel data bus |
| sel_lo_n | input | 1 | Active-low select, low byte lane |
| sel_hi_n | input | 1 | Active-low select, high byte lane |
| wr_n | input | 1 | Active-low write strobe for the input register |
| ld_n | input | 1 | Active-low load strobe for the DAC register |
| clr_n | input | 1 | Active-low clear of both registers |
| clr_mid | input | 1 | Clear and reset value select: 1 gives midscale, 0 gives zero |
| code_out | output | 16 | DAC register contents |
| code_chg | output | 1 | One-cycle flag after the DAC code changes |

## Verification
Clear can land in the same cycle as a fully transparent write-and-load. The bench provokes this by dropping `clr_n` while `wr_n`, both selects and `ld_n` are low and the bus carries a non-clear word. It then expects the clear value at the output, not the bus word. It then releases clear and every strobe in the same cycle. Next it pulses only `ld_n`, which shows that the input register was also cleared and not just the output. Running clear once with each `clr_mid` level separates the two clear values.

// File: rtl/dbd_pkg.sv
package dbd_pkg;

  // Control pins grouped so they cross the clock boundary as one vector.
  typedef struct packed {
    logic clr_n;
    logic mid;
    logic sel_lo_n;
    logic sel_hi_n;
    logic wr_n;
    logic ld_n;
  } ctrl_t;

  // A byte lane is open while the write strobe and its select are both low.
  function automatic logic lane_enable(input logic wr_n, input logic sel_n);
    return (~wr_n) & (~sel_n);
  endfunction

  // The DAC stage is open while the load strobe is low.
  function automatic logic load_enable(input logic ld_n);
    return ~ld_n;
  endfunction

endpackage

// File: rtl/dbd_sync_bank.sv
module dbd_sync_bank #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rst_val,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= rst_val;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/dbd_input_reg.sv
module dbd_input_reg #(
  parameter int LANE_W    = 8,
  parameter int NUM_LANES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_LANES*LANE_W-1:0] por_val,
  input  logic                        clr_act,
  input  logic [NUM_LANES*LANE_W-1:0] clr_val,
  input  logic                        wr_n_s,
  input  logic [NUM_LANES-1:0]        sel_n_s,
  input  logic [NUM_LANES*LANE_W-1:0] bus_s,
  output logic [NUM_LANES*LANE_W-1:0] in_q,
  output logic [NUM_LANES*LANE_W-1:0] in_next,
  output logic [NUM_LANES-1:0]        lane_open
);

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    assign lane_open[l] = dbd_pkg::lane_enable(wr_n_s, sel_n_s[l]);

    always_comb begin
      if (clr_act)
        in_next[l*LANE_W +: LANE_W] = clr_val[l*LANE_W +: LANE_W];
      else if (lane_open[l])
        in_next[l*LANE_W +: LANE_W] = bus_s[l*LANE_W +: LANE_W];
      else
        in_next[l*LANE_W +: LANE_W] = in_q[l*LANE_W +: LANE_W];
    end

    // R2 (lane 0) and R3 (lane 1): an open lane tracks the aligned bus.
    p_lane_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_act && lane_open[l]) |=> in_q[l*LANE_W +: LANE_W] == $past(bus_s[l*LANE_W +: LANE_W]));

    // R5: a closed lane keeps its byte.
    p_lane_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_act && !lane_open[l]) |=> $stable(in_q[l*LANE_W +: LANE_W]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) in_q <= por_val;
    else        in_q <= in_next;
  end

  // R9: clear reaches the input register whatever the strobes do.
  p_in_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act |=> in_q == $past(clr_val));

endmodule

// File: rtl/dbd_dac_reg.sv
module dbd_dac_reg #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] por_val,
  input  logic              clr_act,
  input  logic [DATA_W-1:0] clr_val,
  input  logic              ld_n_s,
  input  logic [DATA_W-1:0] src,
  output logic [DATA_W-1:0] dac_q,
  output logic              code_chg
);

  logic              ld_open;
  logic [DATA_W-1:0] dac_next;
  logic [DATA_W-1:0] dac_prev;

  assign ld_open = dbd_pkg::load_enable(ld_n_s);

  always_comb begin
    if (clr_act)      dac_next = clr_val;
    else if (ld_open) dac_next = src;
    else              dac_next = dac_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dac_q    <= por_val;
      dac_prev <= por_val;
    end else begin
      dac_q    <= dac_next;
      dac_prev <= dac_q;
    end
  end

  assign code_chg = (dac_q != dac_prev);

  // R6: a closed load stage holds the DAC code.
  p_dac_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_act && !ld_open) |=> $stable(dac_q));

  // R6: an open load stage takes the input register's next value.
  p_dac_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_act && ld_open) |=> dac_q == $past(src));

  // R9: clear wins over any load in the same cycle.
  p_dac_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act |=> dac_q == $past(clr_val));

  // R10: two quiet cycles in a row leave the change flag low.
  p_chg_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_act && !ld_open && $past(!clr_act && !ld_open)) |=> !code_chg);

endmodule

// File: rtl/dbd_dac_front.sv
module dbd_dac_front #(
  parameter int LANE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*LANE_W-1:0] bus_in,
  input  logic                sel_lo_n,
  input  logic                sel_hi_n,
  input  logic                wr_n,
  input  logic                ld_n,
  input  logic                clr_n,
  input  logic                clr_mid,
  output logic [2*LANE_W-1:0] code_out,
  output logic                code_chg
);

  import dbd_pkg::*;

  localparam int NUM_LANES = 2;
  localparam int DATA_W    = NUM_LANES * LANE_W;
  localparam int CTRL_W    = $bits(ctrl_t);

  // Midscale sets only the top bit; zero scale is all zeros.
  function automatic logic [DATA_W-1:0] clear_word(input logic mid);
    logic [DATA_W-1:0] w;
    w = '0;
    w[DATA_W-1] = mid;
    return w;
  endfunction

  ctrl_t             ctrl_raw;
  ctrl_t             ctrl_rst;
  ctrl_t             ctrl_s;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] bus_s;
  logic [DATA_W-1:0] por_val;
  logic              clr_act;
  logic [DATA_W-1:0] clr_val;
  logic [DATA_W-1:0] in_q;
  logic [DATA_W-1:0] in_next;
  logic [NUM_LANES-1:0] lane_open;
  logic [NUM_LANES-1:0] sel_n_s;
  logic              wr_prev;
  logic              wr_rise;
  logic              full_thru;

  assign ctrl_raw = '{clr_n: clr_n, mid: clr_mid, sel_lo_n: sel_lo_n,
                      sel_hi_n: sel_hi_n, wr_n: wr_n, ld_n: ld_n};
  assign ctrl_rst = '{clr_n: 1'b1, mid: clr_mid, sel_lo_n: 1'b1,
                      sel_hi_n: 1'b1, wr_n: 1'b1, ld_n: 1'b1};

  dbd_sync_bank #(.W(CTRL_W), .STAGES(SYNC_STAGES)) u_ctrl_sync (
    .clk(clk), .rst_n(rst_n), .rst_val(ctrl_rst), .d(ctrl_raw), .q(ctrl_q)
  );
  assign ctrl_s = ctrl_q;

  // Data gets the same delay as the controls so both arrive together.
  dbd_sync_bank #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_bus_align (
    .clk(clk), .rst_n(rst_n), .rst_val('0), .d(bus_in), .q(bus_s)
  );

  assign por_val = clear_word(clr_mid);
  assign clr_act = ~ctrl_s.clr_n;
  assign clr_val = clear_word(ctrl_s.mid);
  assign sel_n_s = {ctrl_s.sel_hi_n, ctrl_s.sel_lo_n};

  dbd_input_reg #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_in_reg (
    .clk(clk), .rst_n(rst_n), .por_val(por_val), .clr_act(clr_act),
    .clr_val(clr_val), .wr_n_s(ctrl_s.wr_n), .sel_n_s(sel_n_s),
    .bus_s(bus_s), .in_q(in_q), .in_next(in_next), .lane_open(lane_open)
  );

  dbd_dac_reg #(.DATA_W(DATA_W)) u_dac_reg (
    .clk(clk), .rst_n(rst_n), .por_val(por_val), .clr_act(clr_act),
    .clr_val(clr_val), .ld_n_s(ctrl_s.ld_n), .src(in_next),
    .dac_q(code_out), .code_chg(code_chg)
  );

  // Rising edge of the synchronised write strobe, brought out for checking.
  always_ff @(posedge clk) begin
    if (!rst_n) wr_prev <= 1'b1;
    else        wr_prev <= ctrl_s.wr_n;
  end
  assign wr_rise   = ctrl_s.wr_n & ~wr_prev;
  assign full_thru = (&lane_open) & ~ctrl_s.ld_n & ctrl_s.clr_n;

  // R5: the cycle the write strobe rises, the input register does not move.
  p_wr_rise_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && !clr_act) |=> $stable(in_q));

  // R7: both stages open means the aligned bus word becomes the code.
  p_passthru_r7: assert property (@(posedge clk) disable iff (!rst_n)
    full_thru |=> code_out == $past(bus_s));

  // R9: clear value is midscale or zero, never anything else.
  p_clear_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act |=> (code_out == {1'b1, {(DATA_W-1){1'b0}}} || code_out == '0));

endmodule

// File: tb/dbd_dac_front_tb_top.sv
module dbd_dac_front_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_in = 16'h0000;
  logic        sel_lo_n = 1'b1, sel_hi_n = 1'b1, wr_n = 1'b1, ld_n = 1'b1;
  logic        clr_n = 1'b1, clr_mid = 1'b0;
  logic [15:0] code_out;
  logic        code_chg;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;  // 125 MHz

  dbd_dac_front dut_i (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .sel_lo_n(sel_lo_n),
    .sel_hi_n(sel_hi_n), .wr_n(wr_n), .ld_n(ld_n), .clr_n(clr_n),
    .clr_mid(clr_mid), .code_out(code_out), .code_chg(code_chg)
  );

  // Row: {req[4:0], clr_n, mid, sel_lo_n, sel_hi_n, wr_n, ld_n, bus[15:0], expected code[15:0]}
  localparam int NV = 21;
  localparam logic [42:0] VEC [NV] = '{
    {5'd2,  6'b1_0_0_1_0_1, 16'h12AB, 16'h0000},  // R2 low lane open, no load
    {5'd5,  6'b1_0_0_1_1_1, 16'hFFFF, 16'h0000},  // R5 write closed, bus ignored
    {5'd6,  6'b1_0_1_1_1_0, 16'hFFFF, 16'h00AB},  // R6 load shows held low byte
    {5'd6,  6'b1_0_1_1_1_1, 16'h5555, 16'h00AB},  // R6 load closed holds
    {5'd3,  6'b1_0_1_0_0_1, 16'hCD00, 16'h00AB},  // R3 high lane second
    {5'd5,  6'b1_0_1_1_1_1, 16'hEE11, 16'h00AB},  // R5 hold
    {5'd6,  6'b1_0_1_1_1_0, 16'h0000, 16'hCDAB},  // R6 load with selects high
    {5'd6,  6'b1_0_1_1_1_1, 16'h0000, 16'hCDAB},  // R6
    {5'd4,  6'b1_0_0_0_0_1, 16'h1357, 16'hCDAB},  // R4 word write
    {5'd4,  6'b1_0_1_1_1_0, 16'h2468, 16'h1357},  // R4 word visible after load
    {5'd7,  6'b1_0_0_0_0_0, 16'hA5A5, 16'hA5A5},  // R7 flow-through
    {5'd7,  6'b1_0_0_0_0_0, 16'h0F0F, 16'h0F0F},  // R7
    {5'd8,  6'b1_0_1_0_0_0, 16'h7777, 16'h770F},  // R8 high lane live
    {5'd8,  6'b1_0_0_1_0_0, 16'h1234, 16'h7734},  // R8 low lane live
    {5'd5,  6'b1_0_1_1_1_1, 16'h9999, 16'h7734},  // R5 all closed
    {5'd9,  6'b0_1_0_0_0_0, 16'h4321, 16'h8000},  // R9 clear beats write+load
    {5'd9,  6'b1_1_1_1_1_1, 16'h4321, 16'h8000},  // R9 release together
    {5'd9,  6'b1_1_1_1_1_0, 16'h4321, 16'h8000},  // R9 input reg was cleared
    {5'd9,  6'b0_0_1_1_1_1, 16'h4321, 16'h0000},  // R9 zero-scale clear
    {5'd9,  6'b1_0_1_1_1_0, 16'h4321, 16'h0000},  // R9 input reg zero too
    {5'd6,  6'b1_0_1_1_1_1, 16'hBEEF, 16'h0000}   // R6
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic mid);
    @(negedge clk);
    rst_n = 1'b0; clr_mid = mid;
    sel_lo_n = 1'b1; sel_hi_n = 1'b1; wr_n = 1'b1; ld_n = 1'b1; clr_n = 1'b1;
    settle(3);
    rst_n = 1'b1;
    settle(1);
  endtask

  initial begin
    // R1: zero-scale reset
    do_reset(1'b0);
    chk("R1", code_out, 16'h0000);
    chk("R1", {15'd0, code_chg}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      {clr_n, clr_mid, sel_lo_n, sel_hi_n, wr_n, ld_n, bus_in} = VEC[i][37:16];
      settle(5);
      chk($sformatf("R%0d vec%0d", VEC[i][42:38], i), code_out, VEC[i][15:0]);
    end

    // R7 latency and R10 pulse: open both stages on a known word.
    {clr_n, clr_mid, sel_lo_n, sel_hi_n, wr_n, ld_n} = 6'b1_0_0_0_0_0;
    bus_in = 16'h0000;
    settle(5);
    chk("R10", {15'd0, code_chg}, 16'h0000);
    bus_in = 16'h6C6C;
    settle(2);
    chk("R7", code_out, 16'h0000);
    chk("R10", {15'd0, code_chg}, 16'h0000);
    settle(1);
    chk("R7", code_out, 16'h6C6C);
    chk("R10", {15'd0, code_chg}, 16'h0001);
    settle(1);
    chk("R10", {15'd0, code_chg}, 16'h0000);
    chk("R7", code_out, 16'h6C6C);

    // R1: midscale reset
    do_reset(1'b1);
    chk("R1", code_out, 16'h8000);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule